// File: doc/BRIEF.md
# Table-Driven Host Clock Divider

This block turns a fast bus clock into a one-cycle clock-enable tick for a host controller. The divide ratio is not a free integer: a 3-bit code selects one of eight fixed ratios (1, 2, 4, 6, 8, 16, 24 or 32). The tick repeats every N bus cycles, where N is the selected ratio.

The code comes either from a select input or, in automatic mode, from a selector. The selector is given the bus clock frequency in MHz as an unsigned binary number. It looks for the largest ratio that places the divided rate inside a window of 150 to 300 MHz, both limits included. When no ratio fits, it raises an error flag and falls back to ratio 1.

A new code is taken in only while the divider reset is held. The latched code, the error flag and the enable bit are presented on readback outputs, so software can confirm the configuration it wrote.

Top module: `hclk_div_top`

## Requirements
- R1: With latched code c, `tick` pulses high for exactly one bus cycle out of every N. N is 1, 2, 4, 6, 8, 16, 24 or 32 for c = 0, 1, 2, 3, 4, 5, 6, 7.
- R2: In automatic mode (`auto_mode`=1), the code latched during divider reset is the highest c for which floor(`bus_mhz` / N(c)) lies between 150 and 300 inclusive. `bus_mhz` is unsigned binary in MHz.
- R3: In automatic mode, when no code meets the window, `rb_err` reads 1 and the latched code is 0. In manual mode `rb_err` reads 0.
- R4: While `div_rst` is high, `tick` stays 0.
- R5: `sel_code` and the automatic choice are latched only on edges where `div_rst` is high. Changing them while the divider runs has no effect on `rb_code` or on the tick period. This includes a change driven in the same cycle that `div_rst` falls.
- R6: After `div_rst` falls, with the enable set, the first tick follows the N-th rising edge at which `div_rst` is low.
- R7: `rb_en` shows `clk_en` as sampled at the previous edge. While `rb_en` is 0, `tick` is 0 and the count is held at zero. After re-enabling, the first tick follows the N-th edge after the one that sets `rb_en`.
- R8: In manual mode, `rb_code` reads back exactly the `sel_code` value latched during divider reset.
- R9: With code 0, `tick` is high on every cycle while the divider runs.
- R10: After `rst`, `tick`, `rb_code`, `rb_err` and `rb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high block reset |
| div_rst | input | 1 | Divider reset: holds the tick off and opens the code latch |
| clk_en | input | 1 | Output enable bit |
| auto_mode | input | 1 | 1 selects the automatic code, 0 selects `sel_code` |
| sel_code | input | 3 | Manual ratio code |
| bus_mhz | input | BUS_W (12) | Bus clock frequency in MHz, unsigned |
| tick | output | 1 | One-cycle pulse at the divided rate |
| rb_code | output | 3 | Latched code readback |
| rb_err | output | 1 | No-fit flag from the automatic selection |
| rb_en | output | 1 | Latched enable readback |

## Verification
The release of `div_rst` and a change of `sel_code` can fall in the same cycle. The bench provokes this by driving both together right after an edge that latched code 2. The release edge must not take the new value: `rb_code` has to stay 2 and ticks must arrive every 4 cycles from the release. Turning the enable back on is also judged cycle by cycle. The edge that loads `rb_en` must not count, so the first tick lands N+1 edges after `clk_en` is raised.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

    localparam int unsigned NUM_CODES = 8;
    localparam int unsigned CODE_W    = $clog2(NUM_CODES);
    localparam int unsigned MAX_RATIO = 32;
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Output of the automatic selector / content of the code latch
    typedef struct packed {
        code_t code;
        logic  err;
    } choice_t;

    // Divide ratio for each code (non-uniform table)
    function automatic int unsigned ratio_of(input int unsigned c);
        case (c)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            4:       return 8;
            5:       return 16;
            6:       return 24;
            default: return 32;
        endcase
    endfunction

    // Terminal count (ratio minus one) in counter width
    function automatic cnt_t last_of(input code_t c);
        return cnt_t'(ratio_of(int'(c)) - 1);
    endfunction

endpackage

// File: rtl/hclk_auto_sel.sv
module hclk_auto_sel
    import hclk_pkg::*;
#(
    parameter int unsigned BUS_W      = 12,
    parameter int unsigned WIN_LO_MHZ = 150,
    parameter int unsigned WIN_HI_MHZ = 300
) (
    input  logic [BUS_W-1:0] bus_mhz,
    output choice_t          pick
);

    localparam int unsigned EXT_W = 32;

    logic [EXT_W-1:0]     bus_ext;
    logic [NUM_CODES-1:0] fits;

    assign bus_ext = EXT_W'(bus_mhz);

    // floor(bus/R) in [LO,HI]  <=>  LO*R <= bus <= (HI+1)*R-1
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_win
        localparam int unsigned R    = ratio_of(g);
        localparam int unsigned LO_B = WIN_LO_MHZ * R;
        localparam int unsigned HI_B = (WIN_HI_MHZ + 1) * R - 1;
        assign fits[g] = (bus_ext >= EXT_W'(LO_B)) && (bus_ext <= EXT_W'(HI_B));
    end

    // Search from the top code down: ascending loop, last hit wins
    always_comb begin
        pick.code = '0;
        pick.err  = 1'b1;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (fits[i]) begin
                pick.code = code_t'(i);
                pick.err  = 1'b0;
            end
        end
    end

    // R2: a chosen code really lies inside the window
    always_comb begin
        if (!pick.err) begin
            a_pick_fits_r2: assert (fits[pick.code]);
        end
    end

endmodule

// File: rtl/hclk_code_latch.sv
module hclk_code_latch
    import hclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    div_rst,
    input  logic    auto_mode,
    input  code_t   sel_code,
    input  choice_t auto_pick,
    input  logic    clk_en,
    output choice_t cur,
    output logic    en_q
);

    choice_t nxt;

    always_comb begin
        if (auto_mode) begin
            nxt = auto_pick;
        end else begin
            nxt.code = sel_code;
            nxt.err  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= clk_en;
            if (div_rst) begin
                cur <= nxt;
            end
        end
    end

    p_code_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !div_rst |=> $stable(cur));

    p_fallback_zero_r3: assert property (@(posedge clk) disable iff (rst)
        cur.err |-> (cur.code == '0));

    p_manual_noerr_r3: assert property (@(posedge clk) disable iff (rst)
        (div_rst && !auto_mode) |=> !cur.err);

endmodule

// File: rtl/hclk_tick_ctr.sv
module hclk_tick_ctr
    import hclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  code_t code,
    output logic  tick
);

    cnt_t cnt;
    cnt_t last;

    assign last = last_of(code);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + cnt_t'(1);
            tick <= 1'b0;
        end
    end

    p_hold_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        hold |=> !tick);

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && (last != '0)) |=> !tick);

    p_every_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (!hold && (last == '0)) |=> tick);

endmodule

// File: rtl/hclk_div_top.sv
module hclk_div_top
    import hclk_pkg::*;
#(
    parameter int unsigned BUS_W      = 12,
    parameter int unsigned WIN_LO_MHZ = 150,
    parameter int unsigned WIN_HI_MHZ = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_rst,
    input  logic             clk_en,
    input  logic             auto_mode,
    input  logic [2:0]       sel_code,
    input  logic [BUS_W-1:0] bus_mhz,
    output logic             tick,
    output logic [2:0]       rb_code,
    output logic             rb_err,
    output logic             rb_en
);

    choice_t auto_pick;
    choice_t cur;
    logic    en_q;
    logic    hold;

    hclk_auto_sel #(
        .BUS_W      (BUS_W),
        .WIN_LO_MHZ (WIN_LO_MHZ),
        .WIN_HI_MHZ (WIN_HI_MHZ)
    ) u_sel (
        .bus_mhz (bus_mhz),
        .pick    (auto_pick)
    );

    hclk_code_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .div_rst   (div_rst),
        .auto_mode (auto_mode),
        .sel_code  (code_t'(sel_code)),
        .auto_pick (auto_pick),
        .clk_en    (clk_en),
        .cur       (cur),
        .en_q      (en_q)
    );

    assign hold = div_rst || !en_q;

    hclk_tick_ctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .code (cur.code),
        .tick (tick)
    );

    assign rb_code = 3'(cur.code);
    assign rb_err  = cur.err;
    assign rb_en   = en_q;

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !tick);

endmodule

// File: tb/sim_hclk_div_top.sv
module sim_hclk_div_top;

    localparam int BUS_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             div_rst = 1'b1;
    logic             clk_en = 1'b0;
    logic             auto_mode = 1'b0;
    logic [2:0]       sel_code = 3'd0;
    logic [BUS_W-1:0] bus_mhz = '0;
    logic             tick;
    logic [2:0]       rb_code;
    logic             rb_err;
    logic             rb_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hclk_div_top #(.BUS_W(BUS_W)) u0 (
        .clk (clk), .rst (rst), .div_rst (div_rst), .clk_en (clk_en),
        .auto_mode (auto_mode), .sel_code (sel_code), .bus_mhz (bus_mhz),
        .tick (tick), .rb_code (rb_code), .rb_err (rb_err), .rb_en (rb_en)
    );

    function automatic int ratio(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 6;
            4: return 8;  5: return 16; 6: return 24; default: return 32;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Latch code c in manual mode, release, then change sel_code at once
    task automatic run_code(input int c);
        int n;
        n = ratio(c);
        auto_mode = 1'b0; clk_en = 1'b1; div_rst = 1'b1; sel_code = 3'(c);
        step(); step();
        chk("R8 rb_code", int'(rb_code), c);
        chk("R4 tick in reset", int'(tick), 0);
        chk("R3 manual err", int'(rb_err), 0);
        div_rst = 1'b0;
        sel_code = 3'(7 - c);
        for (int k = 1; k <= 3 * n + 2; k++) begin
            step();
            if (n == 1)
                chk("R9 every cycle", int'(tick), 1);
            else if (k <= n)
                chk("R6 first tick", int'(tick), (k == n) ? 1 : 0);
            else
                chk("R1 period", int'(tick), (k % n == 0) ? 1 : 0);
        end
        chk("R5 code held", int'(rb_code), c);
        div_rst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4 held", int'(tick), 0);
        end
    endtask

    initial begin
        step(); step();
        chk("R10 tick", int'(tick), 0);
        chk("R10 rb_code", int'(rb_code), 0);
        chk("R10 rb_err", int'(rb_err), 0);
        chk("R10 rb_en", int'(rb_en), 0);
        rst = 1'b0;

        for (int c = 0; c < 8; c++) run_code(c);

        // Same-cycle release and code change
        auto_mode = 1'b0; clk_en = 1'b1; div_rst = 1'b1; sel_code = 3'd2;
        step(); step();
        div_rst = 1'b0; sel_code = 3'd5;
        for (int k = 1; k <= 12; k++) begin
            step();
            chk("R5 same-cycle period", int'(tick), (k % 4 == 0) ? 1 : 0);
        end
        chk("R5 same-cycle code", int'(rb_code), 2);

        // Enable gating with ratio 8
        div_rst = 1'b1; sel_code = 3'd4;
        step(); step();
        div_rst = 1'b0;
        repeat (5) step();
        clk_en = 1'b0;
        step();
        for (int k = 0; k < 20; k++) begin
            step();
            chk("R7 disabled tick", int'(tick), 0);
            chk("R7 rb_en", int'(rb_en), 0);
        end
        clk_en = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            step();
            chk("R7 re-enable", int'(tick), (k > 1 && (k - 1) % 8 == 0) ? 1 : 0);
        end
        chk("R7 rb_en set", int'(rb_en), 1);

        // Automatic selection sweep
        auto_mode = 1'b1; div_rst = 1'b1;
        for (int b = 0; b < (1 << BUS_W); b++) begin
            int exp_code;
            int exp_err;
            exp_code = 0; exp_err = 1;
            for (int c = 7; c >= 0; c--) begin
                int q;
                q = b / ratio(c);
                if (exp_err == 1 && q >= 150 && q <= 300) begin
                    exp_code = c; exp_err = 0;
                end
            end
            bus_mhz = BUS_W'(b);
            step();
            chk("R2 auto code", int'(rb_code), exp_code);
            chk("R3 auto err", int'(rb_err), exp_err);
        end

        // Automatic choice drives the tick period: 1000 MHz -> code 3 (ratio 6)
        bus_mhz = BUS_W'(1000);
        step();
        div_rst = 1'b0;
        bus_mhz = BUS_W'(100);
        for (int k = 1; k <= 12; k++) begin
            step();
            chk("R2 auto period", int'(tick), (k % 6 == 0) ? 1 : 0);
        end
        chk("R5 auto code held", int'(rb_code), 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule